// File: doc/BRIEF.md
# Banked Binary-Point and Priority-Mask Register Front End

This block is the register side of the per-processor interface of an interrupt controller that serves several CPUs. A simple register bus reaches it. Each access carries a CPU index, a byte offset, a read or write strobe, 32-bit write data and a flag saying whether the access is secure. For every CPU the block holds an 8-bit priority mask and two 3-bit binary point values. One binary point value is the primary (secure) copy and the other is the non-secure copy. Two static inputs set the configuration: whether security extensions are present, and whether interrupt groups are supported.

Which binary point copy an access reaches depends on the offset, the security flag and the configuration. Each copy clamps written values to its own minimum. A write to the end-of-interrupt offset is not stored. It is turned into a one-cycle strobe that carries the CPU index and a 10-bit interrupt ID, and the completion logic downstream consumes it.

Top module: `cpuif_bank_regs`

## Requirements
- R1: After reset, every priority mask and every primary binary point copy is 0, every non-secure binary point copy is 1, `rd_data` is 0 and `eoi_valid` is 0.
- R2: Offset 0x04 holds an 8-bit priority mask for each CPU. A write stores `wr_data[7:0]` and a read returns it in bits 7:0.
- R3: At offset 0x08, a secure access, or any access while `sec_ext_en` is 0, reaches the primary copy. A write stores `wr_data[2:0]` unchanged, because that copy's minimum is 0.
- R4: At offset 0x08, a non-secure access while `sec_ext_en` is 1 reaches the non-secure copy. A write stores the larger of `wr_data[2:0]` and 1, and the primary copy is left unchanged.
- R5: At offset 0x1C, when `groups_en` is 1, a secure access reaches the non-secure copy, and so does any access while `sec_ext_en` is 0. A write stores the larger of `wr_data[2:0]` and 1.
- R6: While `groups_en` is 0, offset 0x1C reads as zero and writes to it change nothing.
- R7: While `sec_ext_en` is 1, a non-secure access to offset 0x1C reads as zero and its writes change nothing.
- R8: A write to offset 0x10 raises `eoi_valid` for exactly the next cycle, with `eoi_id` = `wr_data[9:0]` and `eoi_cpu` = the CPU index. A read of 0x10 returns zero.
- R9: Each CPU's registers are separate. An access with one CPU index never changes another CPU's values.
- R10: `rd_data` carries the read result in the cycle after `rd_en` and is zero in any cycle that does not follow a read. Bits above the width of the register that was read are zero.
- R11: An offset other than 0x04, 0x08, 0x10 and 0x1C reads as zero and ignores writes. A CPU index of `NUM_CPU` or above reads as zero, ignores writes and raises no end-of-interrupt strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_ext_en | input | 1 | Static: security extensions present |
| groups_en | input | 1 | Static: interrupt groups supported |
| acc_cpu | input | CPU_IDX_W | CPU index of the access |
| acc_off | input | 8 | Byte offset of the access |
| acc_secure | input | 1 | Access is secure |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_id | output | 10 | Interrupt ID being completed |
| eoi_cpu | output | CPU_IDX_W | CPU that wrote the end-of-interrupt |

## Verification
On every cycle, the assertions check the following. No non-secure copy ever holds a value below 1. Read data is zero in cycles that do not follow a read, and above bit 7 in all cycles. Every end-of-interrupt strobe is caused by a valid write, and its ID matches that write. Write-ignored accesses (out-of-range CPU index, or the alias offset in a refused state) leave all stored copies unchanged. The bench scenarios are needed for the rest: which copy each combination of offset, security flag and configuration reaches, the value each minimum clamp produces, and the separation between CPUs. Those can only be shown by writing through one view and reading back through another.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;

  localparam int OFF_W = 8;

  // Byte offsets decoded by the front end; software depends on these.
  localparam logic [OFF_W-1:0] OFF_PMASK = 8'h04;
  localparam logic [OFF_W-1:0] OFF_BPT   = 8'h08;
  localparam logic [OFF_W-1:0] OFF_EOI   = 8'h10;
  localparam logic [OFF_W-1:0] OFF_BPT_A = 8'h1C;

  localparam int PMASK_W = 8;
  localparam int BPT_W   = 3;
  localparam int EOI_W   = 10;

  localparam int BPT_PRI_MIN = 0;
  localparam int BPT_NS_MIN  = BPT_PRI_MIN + 1;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_PMASK  = 3'd1,
    TGT_BPT_P  = 3'd2,
    TGT_BPT_NS = 3'd3,
    TGT_EOI    = 3'd4
  } tgt_e;

endpackage

// File: rtl/cpuif_decode.sv
module cpuif_decode
  import cpuif_pkg::*;
#(
  parameter int NUM_CPU   = 8,
  parameter int CPU_IDX_W = 4
) (
  input  logic [OFF_W-1:0]     off,
  input  logic [CPU_IDX_W-1:0] cpu,
  input  logic                 secure,
  input  logic                 sec_ext_en,
  input  logic                 groups_en,
  output tgt_e                 tgt,
  output logic                 cpu_ok
);

  localparam int PAD_W = 32 - CPU_IDX_W;

  logic ns_view;
  logic alias_refused;

  assign cpu_ok        = ({{PAD_W{1'b0}}, cpu} < NUM_CPU);
  assign ns_view       = sec_ext_en & ~secure;
  assign alias_refused = ~groups_en | ns_view;

  always_comb begin
    tgt = TGT_NONE;
    unique case (off)
      OFF_PMASK: tgt = TGT_PMASK;
      OFF_BPT:   tgt = ns_view ? TGT_BPT_NS : TGT_BPT_P;
      OFF_EOI:   tgt = TGT_EOI;
      OFF_BPT_A: tgt = alias_refused ? TGT_NONE : TGT_BPT_NS;
      default:   tgt = TGT_NONE;
    endcase
  end

endmodule

// File: rtl/cpuif_reg_bank.sv
module cpuif_reg_bank #(
  parameter int NUM_CPU = 8,
  parameter int DATA_W  = 8,
  parameter int RST_VAL = 0,
  parameter int MIN_VAL = 0,
  parameter int SEL_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [SEL_W-1:0]                sel,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  output logic [NUM_CPU-1:0][DATA_W-1:0]  all_q
);

  localparam logic [DATA_W-1:0] RST_V = DATA_W'(RST_VAL);
  localparam logic [DATA_W-1:0] MIN_V = DATA_W'(MIN_VAL);

  logic [DATA_W-1:0] wval;

  generate
    if (MIN_VAL == 0) begin : g_noclamp
      assign wval = wdata;
    end else begin : g_clamp
      assign wval = (wdata < MIN_V) ? MIN_V : wdata;
    end
  endgenerate

  generate
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst) begin
          all_q[i] <= RST_V;
        end else if (we && (sel == SEL_W'(i))) begin
          all_q[i] <= wval;
        end
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (sel == SEL_W'(i)) rdata = all_q[i];
    end
  end

endmodule

// File: rtl/cpuif_eoi_gen.sv
module cpuif_eoi_gen
  import cpuif_pkg::*;
#(
  parameter int CPU_IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic [EOI_W-1:0]     id_in,
  input  logic [CPU_IDX_W-1:0] cpu_in,
  output logic                 valid,
  output logic [EOI_W-1:0]     id,
  output logic [CPU_IDX_W-1:0] cpu
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      id    <= '0;
      cpu   <= '0;
    end else begin
      valid <= fire;
      if (fire) begin
        id  <= id_in;
        cpu <= cpu_in;
      end
    end
  end

endmodule

// File: rtl/cpuif_bank_regs.sv
module cpuif_bank_regs
  import cpuif_pkg::*;
#(
  parameter int NUM_CPU   = 8,
  parameter int CPU_IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sec_ext_en,
  input  logic                 groups_en,
  input  logic [CPU_IDX_W-1:0] acc_cpu,
  input  logic [7:0]           acc_off,
  input  logic                 acc_secure,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [31:0]          wr_data,
  output logic [31:0]          rd_data,
  output logic                 eoi_valid,
  output logic [9:0]           eoi_id,
  output logic [CPU_IDX_W-1:0] eoi_cpu
);

  localparam int SEL_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  tgt_e              tgt;
  logic              cpu_ok;
  logic [SEL_W-1:0]  sel;
  logic              wr_ok;

  logic [PMASK_W-1:0]                   pmask_rd;
  logic [BPT_W-1:0]                     bpt_p_rd;
  logic [BPT_W-1:0]                     bpt_ns_rd;
  logic [NUM_CPU-1:0][PMASK_W-1:0]      pmask_all;
  logic [NUM_CPU-1:0][BPT_W-1:0]        bpt_p_all;
  logic [NUM_CPU-1:0][BPT_W-1:0]        bpt_ns_all;

  logic [31:0] rd_next;
  logic [31:0] rd_q;

  assign sel   = acc_cpu[SEL_W-1:0];
  assign wr_ok = wr_en & cpu_ok;

  cpuif_decode #(
    .NUM_CPU  (NUM_CPU),
    .CPU_IDX_W(CPU_IDX_W)
  ) u_dec (
    .off       (acc_off),
    .cpu       (acc_cpu),
    .secure    (acc_secure),
    .sec_ext_en(sec_ext_en),
    .groups_en (groups_en),
    .tgt       (tgt),
    .cpu_ok    (cpu_ok)
  );

  cpuif_reg_bank #(
    .NUM_CPU(NUM_CPU), .DATA_W(PMASK_W), .RST_VAL(0), .MIN_VAL(0)
  ) u_pmask (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_ok && (tgt == TGT_PMASK)),
    .sel  (sel),
    .wdata(wr_data[PMASK_W-1:0]),
    .rdata(pmask_rd),
    .all_q(pmask_all)
  );

  cpuif_reg_bank #(
    .NUM_CPU(NUM_CPU), .DATA_W(BPT_W), .RST_VAL(BPT_PRI_MIN), .MIN_VAL(BPT_PRI_MIN)
  ) u_bpt_p (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_ok && (tgt == TGT_BPT_P)),
    .sel  (sel),
    .wdata(wr_data[BPT_W-1:0]),
    .rdata(bpt_p_rd),
    .all_q(bpt_p_all)
  );

  cpuif_reg_bank #(
    .NUM_CPU(NUM_CPU), .DATA_W(BPT_W), .RST_VAL(BPT_NS_MIN), .MIN_VAL(BPT_NS_MIN)
  ) u_bpt_ns (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_ok && (tgt == TGT_BPT_NS)),
    .sel  (sel),
    .wdata(wr_data[BPT_W-1:0]),
    .rdata(bpt_ns_rd),
    .all_q(bpt_ns_all)
  );

  cpuif_eoi_gen #(
    .CPU_IDX_W(CPU_IDX_W)
  ) u_eoi (
    .clk   (clk),
    .rst   (rst),
    .fire  (wr_ok && (tgt == TGT_EOI)),
    .id_in (wr_data[EOI_W-1:0]),
    .cpu_in(acc_cpu),
    .valid (eoi_valid),
    .id    (eoi_id),
    .cpu   (eoi_cpu)
  );

  always_comb begin
    rd_next = '0;
    if (cpu_ok) begin
      case (tgt)
        TGT_PMASK:  rd_next = {{(32-PMASK_W){1'b0}}, pmask_rd};
        TGT_BPT_P:  rd_next = {{(32-BPT_W){1'b0}}, bpt_p_rd};
        TGT_BPT_NS: rd_next = {{(32-BPT_W){1'b0}}, bpt_ns_rd};
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_en ? rd_next : '0;
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/cpuif_bank_chk.sv
module cpuif_bank_chk
  import cpuif_pkg::*;
#(
  parameter int NUM_CPU   = 8,
  parameter int CPU_IDX_W = 4
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            sec_ext_en,
  input logic                            groups_en,
  input logic [CPU_IDX_W-1:0]            acc_cpu,
  input logic [7:0]                      acc_off,
  input logic                            acc_secure,
  input logic                            rd_en,
  input logic                            wr_en,
  input logic [31:0]                     wr_data,
  input logic [31:0]                     rd_data,
  input logic                            eoi_valid,
  input logic [9:0]                      eoi_id,
  input logic [NUM_CPU-1:0][PMASK_W-1:0] pmask_all,
  input logic [NUM_CPU-1:0][BPT_W-1:0]   bpt_p_all,
  input logic [NUM_CPU-1:0][BPT_W-1:0]   bpt_ns_all
);

  localparam int PAD_W = 32 - CPU_IDX_W;

  logic ns_below_min;
  logic cpu_in_range;
  logic eoi_write;
  logic alias_ignored;

  always_comb begin
    ns_below_min = 1'b0;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (bpt_ns_all[i] == '0) ns_below_min = 1'b1;
    end
  end

  assign cpu_in_range  = ({{PAD_W{1'b0}}, acc_cpu} < NUM_CPU);
  assign eoi_write     = wr_en && cpu_in_range && (acc_off == OFF_EOI);
  assign alias_ignored = wr_en && (acc_off == OFF_BPT_A) &&
                         (!groups_en || (sec_ext_en && !acc_secure));

  // R4
  ns_min_chk: assert property (@(posedge clk) disable iff (rst) !ns_below_min);

  // R10
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> (rd_data == 32'd0));

  // R10
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[31:8] == 24'd0);

  // R8
  eoi_cause_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_valid |-> $past(eoi_write));

  // R8
  eoi_id_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_valid |-> (eoi_id == $past(wr_data[9:0])));

  // R6
  alias_wi_chk: assert property (@(posedge clk) disable iff (rst)
    $past(alias_ignored) |-> ($stable(bpt_ns_all) && $stable(bpt_p_all)));

  // R11
  cpu_range_wi_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !cpu_in_range) |->
      ($stable(pmask_all) && $stable(bpt_p_all) && $stable(bpt_ns_all)));

  // R11
  cpu_range_raz_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && !cpu_in_range) |-> (rd_data == 32'd0));

endmodule

bind cpuif_bank_regs cpuif_bank_chk #(
  .NUM_CPU  (NUM_CPU),
  .CPU_IDX_W(CPU_IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sec_ext_en(sec_ext_en),
  .groups_en (groups_en),
  .acc_cpu   (acc_cpu),
  .acc_off   (acc_off),
  .acc_secure(acc_secure),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .eoi_valid (eoi_valid),
  .eoi_id    (eoi_id),
  .pmask_all (pmask_all),
  .bpt_p_all (bpt_p_all),
  .bpt_ns_all(bpt_ns_all)
);

// File: tb/test_cpuif_bank_regs.sv
module test_cpuif_bank_regs;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CPU    = 8;
  localparam int CPU_IDX_W  = 4;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 sec_ext_en = 1'b1;
  logic                 groups_en = 1'b1;
  logic [CPU_IDX_W-1:0] acc_cpu = '0;
  logic [7:0]           acc_off = '0;
  logic                 acc_secure = 1'b0;
  logic                 rd_en = 1'b0;
  logic                 wr_en = 1'b0;
  logic [31:0]          wr_data = '0;
  logic [31:0]          rd_data;
  logic                 eoi_valid;
  logic [9:0]           eoi_id;
  logic [CPU_IDX_W-1:0] eoi_cpu;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpuif_bank_regs #(.NUM_CPU(NUM_CPU), .CPU_IDX_W(CPU_IDX_W)) i_cpuif_bank_regs (
    .clk(clk), .rst(rst), .sec_ext_en(sec_ext_en), .groups_en(groups_en),
    .acc_cpu(acc_cpu), .acc_off(acc_off), .acc_secure(acc_secure),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .eoi_valid(eoi_valid), .eoi_id(eoi_id), .eoi_cpu(eoi_cpu)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(int cpu, logic [7:0] off, logic [31:0] d, logic sec);
    @(negedge clk);
    acc_cpu = CPU_IDX_W'(cpu); acc_off = off; wr_data = d; acc_secure = sec; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int cpu, logic [7:0] off, logic sec, output logic [31:0] v);
    @(negedge clk);
    acc_cpu = CPU_IDX_W'(cpu); acc_off = off; acc_secure = sec; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1", "rd_data after reset", rd_data, 32'd0);
    chk("R1", "eoi_valid after reset", {31'd0, eoi_valid}, 32'd0);
    rd(0, 8'h04, 1'b1, v); chk("R1", "pmask cpu0", v, 32'd0);
    rd(7, 8'h08, 1'b1, v); chk("R1", "primary bpt cpu7", v, 32'd0);
    rd(7, 8'h08, 1'b0, v); chk("R1", "ns bpt cpu7", v, 32'd1);
    rd(0, 8'h1C, 1'b1, v); chk("R1", "alias bpt cpu0", v, 32'd1);
  endtask

  task automatic t_pmask();
    logic [31:0] v;
    wr(2, 8'h04, 32'hFFFF_FFA5, 1'b0);
    rd(2, 8'h04, 1'b0, v); chk("R2", "pmask cpu2 (upper bits zero R10)", v, 32'hA5);
  endtask

  task automatic t_bank();
    logic [31:0] v;
    wr(0, 8'h08, 32'h0, 1'b1);
    rd(0, 8'h08, 1'b1, v); chk("R3", "primary keeps 0", v, 32'd0);
    wr(0, 8'h08, 32'hF5, 1'b1);
    rd(0, 8'h08, 1'b1, v); chk("R3", "primary low 3 bits", v, 32'd5);
    wr(0, 8'h08, 32'h0, 1'b0);
    rd(0, 8'h08, 1'b0, v); chk("R4", "ns clamp to 1", v, 32'd1);
    rd(0, 8'h08, 1'b1, v); chk("R4", "primary untouched by ns write", v, 32'd5);
    wr(0, 8'h08, 32'h6, 1'b0);
    rd(0, 8'h1C, 1'b1, v); chk("R5", "alias shows ns copy", v, 32'd6);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(0, 8'h1C, 32'h0, 1'b1);
    rd(0, 8'h08, 1'b0, v); chk("R5", "alias write clamps to 1", v, 32'd1);
    wr(0, 8'h1C, 32'h3, 1'b1);
    rd(0, 8'h08, 1'b0, v); chk("R5", "alias write stores 3", v, 32'd3);
    wr(0, 8'h1C, 32'h7, 1'b0);
    rd(0, 8'h08, 1'b0, v); chk("R7", "ns alias write ignored", v, 32'd3);
    rd(0, 8'h1C, 1'b0, v); chk("R7", "ns alias read zero", v, 32'd0);
  endtask

  task automatic t_nogroups();
    logic [31:0] v;
    groups_en = 1'b0;
    wr(0, 8'h1C, 32'h7, 1'b1);
    rd(0, 8'h1C, 1'b1, v); chk("R6", "alias reads zero", v, 32'd0);
    rd(0, 8'h08, 1'b0, v); chk("R6", "ns copy kept", v, 32'd3);
    rd(0, 8'h08, 1'b1, v); chk("R6", "primary kept", v, 32'd5);
    groups_en = 1'b1;
  endtask

  task automatic t_nosec();
    logic [31:0] v;
    sec_ext_en = 1'b0;
    wr(0, 8'h08, 32'h4, 1'b0);
    rd(0, 8'h08, 1'b1, v); chk("R3", "no-ext ns access hits primary", v, 32'd4);
    wr(0, 8'h1C, 32'h2, 1'b0);
    rd(0, 8'h1C, 1'b0, v); chk("R5", "no-ext alias any access", v, 32'd2);
    sec_ext_en = 1'b1;
    rd(0, 8'h08, 1'b0, v); chk("R5", "ns copy via 0x08", v, 32'd2);
  endtask

  task automatic t_eoi();
    logic [31:0] v;
    wr(3, 8'h10, 32'hFFFF_F3FF, 1'b0);
    chk("R8", "eoi_valid", {31'd0, eoi_valid}, 32'd1);
    chk("R8", "eoi_id", {22'd0, eoi_id}, 32'h3FF);
    chk("R8", "eoi_cpu", {28'd0, eoi_cpu}, 32'd3);
    @(negedge clk);
    chk("R8", "eoi_valid one cycle", {31'd0, eoi_valid}, 32'd0);
    rd(3, 8'h10, 1'b1, v); chk("R8", "eoi offset reads zero", v, 32'd0);
  endtask

  task automatic t_percpu();
    logic [31:0] v;
    wr(0, 8'h04, 32'h11, 1'b1);
    wr(7, 8'h04, 32'h77, 1'b1);
    rd(0, 8'h04, 1'b1, v); chk("R9", "pmask cpu0", v, 32'h11);
    rd(7, 8'h04, 1'b1, v); chk("R9", "pmask cpu7", v, 32'h77);
    rd(2, 8'h04, 1'b1, v); chk("R9", "pmask cpu2 kept", v, 32'hA5);
    rd(5, 8'h08, 1'b0, v); chk("R9", "ns bpt cpu5 untouched", v, 32'd1);
    rd(5, 8'h08, 1'b1, v); chk("R9", "primary bpt cpu5 untouched", v, 32'd0);
  endtask

  task automatic t_range();
    logic [31:0] v;
    wr(9, 8'h04, 32'h5A, 1'b1);
    rd(9, 8'h04, 1'b1, v); chk("R11", "out-of-range cpu reads zero", v, 32'd0);
    rd(1, 8'h04, 1'b1, v); chk("R11", "aliasing cpu1 unchanged", v, 32'd0);
    wr(9, 8'h10, 32'h12, 1'b1);
    chk("R11", "no eoi for bad cpu", {31'd0, eoi_valid}, 32'd0);
    wr(1, 8'h0C, 32'hFF, 1'b1);
    rd(1, 8'h0C, 1'b1, v); chk("R11", "unmapped offset zero", v, 32'd0);
    rd(1, 8'h05, 1'b1, v); chk("R11", "unaligned offset zero", v, 32'd0);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    rd(7, 8'h04, 1'b1, v); chk("R10", "read data next cycle", v, 32'h77);
    @(negedge clk);
    chk("R10", "rd_data zero without read", rd_data, 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pmask();
    t_bank();
    t_alias();
    t_nogroups();
    t_nosec();
    t_eoi();
    t_percpu();
    t_range();
    t_timing();
    finish_run();
  end

endmodule